// File: doc/BRIEF.md
# Configuration Header Clock-to-Data Ratio Detector

This block taps a 32-bit configuration image stream and never drives or stalls it. After a start-of-image strobe it counts the words accepted on the link. From one early header word it takes an encryption flag, and from a later header word it takes a compression flag. It combines these with the bus width sampled at the strobe and produces a 2-bit clock-to-data ratio code. The code is meant for whatever logic sets up the configuration clock divider.

The tap follows valid/ready rules. A word counts only in a cycle where the producer's valid and the consumer's ready are both high. A cycle in which ready is low is back-pressure on the link and is invisible to the detector, whatever data is shown. The detector has no ready of its own, so it adds no back-pressure. If the image's final beat arrives before the compression word, the detector flags a short header instead of a ratio.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, ratio_code is 0, ratio_valid is 0 and hdr_error is 0. Beats accepted before the first sof strobe are ignored: they give no pulse and no error.
- R2: A word is accepted only in a cycle with tap_valid and tap_ready both high. Data shown with tap_ready low is not counted and not inspected.
- R3: A sof strobe restarts the scan at word index 0. A beat accepted in the same cycle as sof is word 0. The strobe clears hdr_error, sets ratio_code to 0, and samples width_sel (1 = 32-bit bus, 0 = 16-bit bus) for the whole image.
- R4: The image is encrypted when bits [3:2] of word 69 (counted from 0) are nonzero.
- R5: The image is compressed when bit 1 of word 229 is 0.
- R6: Ratio codes are 0 = x1, 1 = x2, 2 = x4 and 3 = x8. An image that is neither encrypted nor compressed gives code 0 at either width.
- R7: A compressed image gives code 2 and an encrypted-only image gives code 1. Either code is raised by one when the sampled width is 32-bit.
- R8: ratio_valid is high for exactly one cycle, the cycle after word 229 is accepted. ratio_code takes its new value in that same cycle and holds it until the next sof.
- R9: If a beat with tap_last is accepted at an index below 229, hdr_error goes high in the next cycle and stays high until sof, and that image gives no ratio_valid. A tap_last on word 229 itself (230 words) is a complete header.
- R10: Once an image has produced a ratio or an error, further beats are ignored until the next sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-image strobe, one cycle |
| width_sel | input | 1 | Bus width, sampled at sof: 1 = 32-bit, 0 = 16-bit |
| tap_valid | input | 1 | Valid of the observed link |
| tap_ready | input | 1 | Ready of the observed link |
| tap_data | input | 32 | Data word of the observed link |
| tap_last | input | 1 | Final beat of the image |
| ratio_code | output | 2 | Clock-to-data ratio code |
| ratio_valid | output | 1 | One-cycle strobe when the ratio is decided |
| hdr_error | output | 1 | Header ended before the compression word |

## Verification
ratio_valid and the new ratio_code appear one clock edge after word 229 is accepted. hdr_error rises one edge after an early final beat is accepted. The clearing done by sof is visible one edge after the strobe. The bench drives every input on the falling edge and samples the outputs at the next falling edge, which is the first point where the registered result can be seen. At the falling edge where word 229 is driven, it also confirms that ratio_valid is still low. At the falling edge after the pulse, it confirms that the pulse has ended.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  typedef enum logic [1:0] {
    SCAN_IDLE    = 2'd0,
    SCAN_COLLECT = 2'd1,
    SCAN_DONE    = 2'd2
  } scan_e;

endpackage

// File: rtl/hdr_word_tracker.sv
module hdr_word_tracker
  import hdr_ratio_pkg::*;
#(
  parameter int LAST_IDX = 229,
  parameter int IDX_W    = $clog2(LAST_IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             beat,
  input  logic             last,
  output logic [IDX_W-1:0] cur_idx,
  output logic             live,
  output logic             decide,
  output logic             short_end
);

  scan_e            state_q;
  logic [IDX_W-1:0] idx_q;

  // A beat in the sof cycle is word zero of the new image.
  assign cur_idx   = sof ? '0 : idx_q;
  assign live      = beat && (sof || state_q == SCAN_COLLECT);
  assign decide    = live && (cur_idx == IDX_W'(LAST_IDX));
  assign short_end = live && last && !decide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
    end else begin
      if (decide || short_end) begin
        state_q <= SCAN_DONE;
      end else if (sof) begin
        state_q <= SCAN_COLLECT;
      end
      if (live) begin
        idx_q <= cur_idx + IDX_W'(1);
      end else if (sof) begin
        idx_q <= '0;
      end
    end
  end

endmodule

// File: rtl/hdr_field_probe.sv
module hdr_field_probe #(
  parameter int IDX_W      = 8,
  parameter int WORD_IDX   = 0,
  parameter int BITS       = 1,
  parameter bit MATCH_ZERO = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             live,
  input  logic [IDX_W-1:0] idx,
  input  logic [BITS-1:0]  field,
  output logic             flag
);

  logic hit;
  logic test_now;
  logic flag_q;

  assign hit = live && (idx == IDX_W'(WORD_IDX));

  generate
    if (MATCH_ZERO) begin : g_zero_test
      assign test_now = (field == '0);
    end else begin : g_nonzero_test
      assign test_now = |field;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= test_now;
    end else if (sof) begin
      flag_q <= 1'b0;
    end
  end

  // Bypass so a flag is usable in the very cycle its word passes.
  assign flag = hit ? test_now : flag_q;

endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
  import hdr_ratio_pkg::*;
(
  input  logic   wide,
  input  logic   enc,
  input  logic   cmp,
  output ratio_e code
);

  logic [1:0] base;

  always_comb begin
    base = cmp ? 2'(RATIO_X4) : 2'(RATIO_X2);
    if (!enc && !cmp) begin
      code = RATIO_X1;
    end else if (wide) begin
      code = ratio_e'(base + 2'd1);
    end else begin
      code = ratio_e'(base);
    end
  end

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ENC_WORD = 69,
  parameter int ENC_LSB  = 2,
  parameter int ENC_BITS = 2,
  parameter int CMP_WORD = 229,
  parameter int CMP_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              width_sel,
  input  logic              tap_valid,
  input  logic              tap_ready,
  input  logic [DATA_W-1:0] tap_data,
  input  logic              tap_last,
  output logic [1:0]        ratio_code,
  output logic              ratio_valid,
  output logic              hdr_error
);

  localparam int IDX_W = $clog2(CMP_WORD + 1);

  logic             beat;
  logic [IDX_W-1:0] cur_idx;
  logic             live;
  logic             decide;
  logic             short_end;
  logic             enc_flag;
  logic             cmp_flag;
  logic             wide_q;
  logic             wide_eff;
  ratio_e           code_next;
  ratio_e           code_q;
  logic             valid_q;
  logic             err_q;

  assign beat = tap_valid && tap_ready;

  hdr_word_tracker #(
    .LAST_IDX (CMP_WORD),
    .IDX_W    (IDX_W)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .beat      (beat),
    .last      (tap_last),
    .cur_idx   (cur_idx),
    .live      (live),
    .decide    (decide),
    .short_end (short_end)
  );

  hdr_field_probe #(
    .IDX_W      (IDX_W),
    .WORD_IDX   (ENC_WORD),
    .BITS       (ENC_BITS),
    .MATCH_ZERO (1'b0)
  ) u_enc_probe (
    .clk   (clk),
    .rst_n (rst_n),
    .sof   (sof),
    .live  (live),
    .idx   (cur_idx),
    .field (tap_data[ENC_LSB +: ENC_BITS]),
    .flag  (enc_flag)
  );

  hdr_field_probe #(
    .IDX_W      (IDX_W),
    .WORD_IDX   (CMP_WORD),
    .BITS       (1),
    .MATCH_ZERO (1'b1)
  ) u_cmp_probe (
    .clk   (clk),
    .rst_n (rst_n),
    .sof   (sof),
    .live  (live),
    .idx   (cur_idx),
    .field (tap_data[CMP_BIT +: 1]),
    .flag  (cmp_flag)
  );

  assign wide_eff = sof ? width_sel : wide_q;

  hdr_ratio_map u_map (
    .wide (wide_eff),
    .enc  (enc_flag),
    .cmp  (cmp_flag),
    .code (code_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b0;
      code_q  <= RATIO_X1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (sof) begin
        wide_q <= width_sel;
      end
      valid_q <= decide;
      if (decide) begin
        code_q <= code_next;
      end else if (sof) begin
        code_q <= RATIO_X1;
      end
      err_q <= short_end || (err_q && !sof);
    end
  end

  assign ratio_code  = code_q;
  assign ratio_valid = valid_q;
  assign hdr_error   = err_q;

endmodule

// File: rtl/hdr_ratio_detect_chk.sv
module hdr_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof,
  input logic       tap_valid,
  input logic       tap_ready,
  input logic       tap_last,
  input logic [1:0] ratio_code,
  input logic       ratio_valid,
  input logic       hdr_error
);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |=> !ratio_valid);

  p_needs_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> $past(tap_valid && tap_ready));

  p_hold_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !(tap_valid && tap_ready)) |=> ($stable(ratio_code) && !ratio_valid));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_error) |-> $past(tap_valid && tap_ready && tap_last));

  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> !hdr_error);

  p_sof_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !(tap_valid && tap_ready)) |=> ((ratio_code == 2'd0) && !hdr_error));

endmodule

bind hdr_ratio_detect hdr_ratio_detect_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sof         (sof),
  .tap_valid   (tap_valid),
  .tap_ready   (tap_ready),
  .tap_last    (tap_last),
  .ratio_code  (ratio_code),
  .ratio_valid (ratio_valid),
  .hdr_error   (hdr_error)
);

// File: tb/hdr_ratio_detect_test.sv
module hdr_ratio_detect_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0;
  logic        width_sel = 1'b0;
  logic        tap_valid = 1'b0;
  logic        tap_ready = 1'b0;
  logic [31:0] tap_data = '0;
  logic        tap_last = 1'b0;
  logic [1:0]  ratio_code;
  logic        ratio_valid;
  logic        hdr_error;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int pulse_cnt = 0;

  always #10 clk = ~clk;

  hdr_ratio_detect uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .width_sel(width_sel),
    .tap_valid(tap_valid), .tap_ready(tap_ready), .tap_data(tap_data),
    .tap_last(tap_last), .ratio_code(ratio_code),
    .ratio_valid(ratio_valid), .hdr_error(hdr_error)
  );

  typedef struct packed {
    logic       w32;
    logic [1:0] enc;
    logic       cmp1;
    logic       stall;
    logic [1:0] exp;
  } vec_t;

  // width, encryption field, word-229 bit 1, stall at word 69, expected code
  localparam vec_t VECS [10] = '{
    '{1'b0, 2'b00, 1'b1, 1'b0, 2'd0},
    '{1'b1, 2'b00, 1'b1, 1'b0, 2'd0},
    '{1'b0, 2'b01, 1'b1, 1'b0, 2'd1},
    '{1'b1, 2'b10, 1'b1, 1'b1, 2'd2},
    '{1'b0, 2'b00, 1'b0, 1'b0, 2'd2},
    '{1'b1, 2'b00, 1'b0, 1'b1, 2'd3},
    '{1'b0, 2'b11, 1'b0, 1'b0, 2'd2},
    '{1'b1, 2'b01, 1'b0, 1'b0, 2'd3},
    '{1'b0, 2'b10, 1'b1, 1'b1, 2'd1},
    '{1'b1, 2'b11, 1'b1, 1'b0, 2'd2}
  };

  always @(negedge clk) if (rst_n && ratio_valid === 1'b1) pulse_cnt++;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_for(int idx, logic [1:0] enc, logic cmp1);
    if (idx == 69) return {28'h5A3C96E, enc, 2'b11};
    if (idx == 229) return {28'hFFFFFFF, 2'b11, cmp1, 1'b1};
    return 32'(idx) * 32'h9E3779B9;
  endfunction

  task automatic send_beat(logic [31:0] d, logic last);
    @(negedge clk);
    sof = 1'b0; tap_valid = 1'b1; tap_ready = 1'b1; tap_data = d; tap_last = last;
  endtask

  task automatic stall_beat(logic [31:0] d);
    @(negedge clk);
    sof = 1'b0; tap_valid = 1'b1; tap_ready = 1'b0; tap_data = d; tap_last = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    sof = 1'b0; tap_valid = 1'b0; tap_ready = 1'b1; tap_last = 1'b0;
  endtask

  task automatic do_sof(logic w32);
    @(negedge clk);
    sof = 1'b1; width_sel = w32; tap_valid = 1'b0; tap_last = 1'b0;
    @(negedge clk);
    sof = 1'b0; width_sel = ~w32;
  endtask

  task automatic send_range(int from, int to, logic [1:0] enc, logic cmp1,
                            int last_idx, logic stall69);
    for (int i = from; i <= to; i++) begin
      if (stall69 && i == 69) stall_beat(word_for(69, ~enc, ~cmp1));
      send_beat(word_for(i, enc, cmp1), i == last_idx);
    end
  endtask

  // Sends word 229 and checks the pulse timing and the code.
  task automatic finish_image(logic [1:0] enc, logic cmp1, logic last,
                              int exp, string req);
    send_beat(word_for(229, enc, cmp1), last);
    check("R8", int'(ratio_valid), 0);
    idle();
    check("R8", int'(ratio_valid), 1);
    check(req, int'(ratio_code), exp);
    check("R9", int'(hdr_error), 0);
    idle();
    check("R8", int'(ratio_valid), 0);
    check("R8", int'(ratio_code), exp);
  endtask

  initial begin
    int pc;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", int'(ratio_code), 0);
    check("R1", int'(ratio_valid), 0);
    check("R1", int'(hdr_error), 0);

    // R1: beats before any sof are ignored
    pc = pulse_cnt;
    send_range(0, 234, 2'b11, 1'b0, 100, 1'b0);
    idle(); idle();
    check("R1", pulse_cnt - pc, 0);
    check("R1", int'(hdr_error), 0);

    // Vector table: R4, R5, R6, R7 and R2 (stall rows)
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      if (v.stall) tag = "R2";
      else if (v.enc == 2'b00 && v.cmp1) tag = "R6";
      else if (v.cmp1) tag = "R4";
      else tag = "R5";
      do_sof(v.w32);
      send_range(0, 228, v.enc, v.cmp1, -1, v.stall);
      finish_image(v.enc, v.cmp1, 1'b0, int'(v.exp), tag);
    end

    // R9: early end at word 100, sticky error, no pulse
    do_sof(1'b0);
    pc = pulse_cnt;
    send_range(0, 100, 2'b00, 1'b0, 100, 1'b0);
    idle();
    check("R9", int'(hdr_error), 1);
    // R10: later beats ignored after error
    send_range(101, 240, 2'b00, 1'b0, -1, 1'b0);
    idle(); idle();
    check("R10", pulse_cnt - pc, 0);
    check("R9", int'(hdr_error), 1);
    check("R9", int'(ratio_code), 0);
    // R3: sof clears error
    do_sof(1'b0);
    check("R3", int'(hdr_error), 0);

    // R9 boundary: last on word 228 is too short
    send_range(0, 228, 2'b01, 1'b1, 228, 1'b0);
    idle();
    check("R9", int'(hdr_error), 1);

    // R9 boundary: last on word 229 completes
    do_sof(1'b1);
    send_range(0, 228, 2'b01, 1'b1, -1, 1'b0);
    finish_image(2'b01, 1'b1, 1'b1, 2, "R9");

    // R10: beats after the decision change nothing
    pc = pulse_cnt;
    send_range(0, 30, 2'b00, 1'b0, -1, 1'b0);
    for (int i = 0; i < 5; i++) send_beat(word_for(229, 2'b00, 1'b0), 1'b0);
    idle(); idle();
    check("R10", pulse_cnt - pc, 0);
    check("R10", int'(ratio_code), 2);
    check("R10", int'(hdr_error), 0);

    // R3: abandoned image restarted; beat in the sof cycle is word 0
    do_sof(1'b0);
    send_range(0, 150, 2'b00, 1'b1, -1, 1'b0);
    @(negedge clk);
    sof = 1'b1; width_sel = 1'b1; tap_valid = 1'b1; tap_ready = 1'b1;
    tap_data = word_for(0, 2'b10, 1'b1); tap_last = 1'b0;
    @(negedge clk);
    sof = 1'b0; width_sel = 1'b0;
    tap_data = word_for(1, 2'b10, 1'b1);
    send_range(2, 228, 2'b10, 1'b1, -1, 1'b0);
    // R7: encrypted only at 32-bit width gives code 2
    finish_image(2'b10, 1'b1, 1'b0, 2, "R7");

    // R3: sof resets the held code to 0
    do_sof(1'b0);
    check("R3", int'(ratio_code), 0);

    summary();
    $finish;
  end

endmodule